// File: doc/BRIEF.md
# SPI Write-Then-Read Round Sequencer

This block drives a shift engine that moves at most a fixed number of bytes per burst (four by default, that is 32 bits). It runs one whole flash-style exchange: a number of bytes to send, then a number of bytes to receive, all inside a single chip-select window. A start pulse latches both counts. The block then cuts the exchange into rounds. Each round first takes as many pending send bytes as fit. Any free lanes left in that round are handed to receive bytes. So one round can carry the last send bytes together with the first receive bytes.

For each round the sequencer does four things in turn:
- It collects the send bytes from a valid/ready input stream and packs them into the transmit word, with the first byte in the highest lane that the round uses.
- It gives the engine the burst length in bits and a one-cycle start pulse.
- It waits for the engine's done pulse.
- It unpacks the received word into a valid/ready output stream. The receive bytes sit in the lowest lanes of the engine's word, first byte highest.

A timeout on the done pulse aborts the exchange, raises a sticky error flag and releases chip select.

Top module: `spi_chunk_seq`

## Requirements
- R1: After reset, `cs_n` is 1 and `busy`, `error`, `wr_ready`, `rd_valid` and `eng_start` are all 0.
- R2: Each round takes `nw = min(sends left, LANES)` and `nr = min(receives left, LANES - nw)`. Rounds follow in order until `nw + nr` would be 0, and a start with both counts zero issues no burst.
- R3: At each `eng_start`, `eng_bits` equals `8*(nw+nr)` for that round, so it is a nonzero multiple of 8 no larger than `8*LANES`.
- R4: In the transmit word of a round with `T = nw+nr` bytes, send byte i of that round sits at bits `[(T-1-i)*8 +: 8]`. Every other lane is zero.
- R5: Receive byte i of a round is `eng_rx[(nr-1-i)*8 +: 8]`, sampled in the cycle `eng_done` is high. The lanes above `nr` are not used.
- R6: Exactly the requested number of bytes pass each stream: send bytes move only when `wr_valid && wr_ready`, receive bytes only when `rd_valid && rd_ready`. `rd_data` holds steady while `rd_valid` waits for `rd_ready`.
- R7: `cs_n` is 0 from the clock edge that accepts start until the exchange ends, and it is 0 at every `eng_start`. At the end it returns to 1.
- R8: `busy` rises on the edge after start is accepted and stays high until `cs_n` is released. `cs_n` is never 0 while `busy` is 0.
- R9: If `eng_done` does not arrive within `TMO_CYCLES` clocks after `eng_start`, the exchange stops. On the same edge `error` goes to 1, `cs_n` to 1 and `busy` to 0, and no receive byte of that round is output.
- R10: `error` stays at 1 while idle and is cleared by the next accepted start.
- R11: `eng_start` is a single-cycle pulse, one for each round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (accepted while idle) |
| wr_count | input | CNT_W | Number of bytes to send |
| rd_count | input | CNT_W | Number of bytes to receive |
| busy | output | 1 | Exchange in progress |
| error | output | 1 | Sticky timeout flag |
| cs_n | output | 1 | Chip select, active low |
| wr_valid | input | 1 | Send byte available |
| wr_ready | output | 1 | Send byte accepted |
| wr_data | input | 8 | Send byte |
| rd_valid | output | 1 | Receive byte available |
| rd_ready | input | 1 | Consumer takes receive byte |
| rd_data | output | 8 | Receive byte |
| eng_start | output | 1 | Burst start pulse to shift engine |
| eng_bits | output | BITS_W | Burst length in bits |
| eng_tx | output | 8*LANES | Transmit word |
| eng_done | input | 1 | Burst complete pulse |
| eng_rx | input | 8*LANES | Received word, valid with eng_done |

## Verification
The bench builds the block with four lanes, 8-bit counts and a timeout of 20 clocks. This makes every send/receive count pair from 0 to 9 cheap to run. The sweep of 100 pairs reaches all mixes of round contents: pure-send rounds, pure-receive rounds, mixed tail/head rounds with every split, partial final rounds and the empty exchange. The short timeout lets a silent engine be tested, followed by recovery on the next start. The stalls on both streams repeat at different rates, so backpressure lands on different bytes in each pair.

// File: rtl/spi_chunk_pkg.sv
package spi_chunk_pkg;

  // Sequencer phases of one exchange
  typedef enum logic [2:0] {
    ST_IDLE,   // chip select released, waiting for start
    ST_PLAN,   // compute the split of the next round
    ST_FILL,   // gather send bytes of the round
    ST_KICK,   // one-cycle burst start
    ST_WAIT,   // wait for engine completion or timeout
    ST_DRAIN   // hand out receive bytes of the round
  } seq_state_t;

endpackage

// File: rtl/spi_round_plan.sv
module spi_round_plan #(
  parameter int CNT_W  = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = $clog2(LANES + 1)
) (
  input  logic [CNT_W-1:0]  wr_left,
  input  logic [CNT_W-1:0]  rd_left,
  output logic [LANE_W-1:0] n_wr,
  output logic [LANE_W-1:0] n_rd,
  output logic              has_work
);

  logic [LANE_W-1:0] room;

  always_comb begin
    // send bytes take precedence for the lanes of a round
    if (wr_left >= CNT_W'(LANES)) begin
      n_wr = LANE_W'(LANES);
    end else begin
      n_wr = wr_left[LANE_W-1:0];
    end
    room = LANE_W'(LANES) - n_wr;
    // leftover lanes go to receive bytes
    if (rd_left >= CNT_W'(room)) begin
      n_rd = room;
    end else begin
      n_rd = rd_left[LANE_W-1:0];
    end
    has_work = (n_wr != '0) || (n_rd != '0);
  end

endmodule

// File: rtl/spi_tx_packer.sv
module spi_tx_packer #(
  parameter int LANES  = 4,
  parameter int SLOT_W = $clog2(LANES),
  parameter int WORD_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [SLOT_W-1:0] slot,
  input  logic [7:0]        din,
  output logic [WORD_W-1:0] word
);

  logic [7:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_en;
    assign lane_en = clr || (push && (slot == SLOT_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
      end else if (lane_en) begin
        lane_q[g] <= clr ? 8'h00 : din;
      end
    end

    assign word[g*8 +: 8] = lane_q[g];
  end

endmodule

// File: rtl/spi_rx_unpacker.sv
module spi_rx_unpacker #(
  parameter int LANES  = 4,
  parameter int SLOT_W = $clog2(LANES),
  parameter int WORD_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [WORD_W-1:0] rx_in,
  input  logic [SLOT_W-1:0] slot,
  output logic [7:0]        dout
);

  logic [7:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
      end else if (cap) begin
        lane_q[g] <= rx_in[g*8 +: 8];
      end
    end
  end

  assign dout = lane_q[slot];

endmodule

// File: rtl/spi_chunk_seq.sv
module spi_chunk_seq
  import spi_chunk_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int LANES      = 4,
  parameter int TMO_CYCLES = 1000,
  localparam int WORD_W    = LANES * 8,
  localparam int BITS_W    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic [CNT_W-1:0]  rd_count,
  output logic              busy,
  output logic              error,
  output logic              cs_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              eng_start,
  output logic [BITS_W-1:0] eng_bits,
  output logic [WORD_W-1:0] eng_tx,
  input  logic              eng_done,
  input  logic [WORD_W-1:0] eng_rx
);

  localparam int LANE_W = $clog2(LANES + 1);
  localparam int SLOT_W = $clog2(LANES);
  localparam int TMO_W  = $clog2(TMO_CYCLES + 1);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  wr_left_q, wr_left_d;
  logic [CNT_W-1:0]  rd_left_q, rd_left_d;
  logic [LANE_W-1:0] nw_q, nw_d;
  logic [LANE_W-1:0] nr_q, nr_d;
  logic [LANE_W-1:0] idx_q, idx_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic              err_q, err_d;
  logic              cs_n_q, cs_n_d;

  logic [LANE_W-1:0] plan_nw, plan_nr;
  logic              plan_work;
  logic [LANE_W-1:0] tot;
  logic              tx_clr, tx_push, rx_cap;
  logic [SLOT_W-1:0] tx_slot, rx_slot;

  spi_round_plan #(
    .CNT_W (CNT_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_plan (
    .wr_left (wr_left_q),
    .rd_left (rd_left_q),
    .n_wr    (plan_nw),
    .n_rd    (plan_nr),
    .has_work(plan_work)
  );

  assign tot     = nw_q + nr_q;
  assign tx_slot = SLOT_W'(tot - idx_q - LANE_W'(1));
  assign rx_slot = SLOT_W'(nr_q - idx_q - LANE_W'(1));

  spi_tx_packer #(.LANES(LANES)) u_pack (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tx_clr),
    .push (tx_push),
    .slot (tx_slot),
    .din  (wr_data),
    .word (eng_tx)
  );

  spi_rx_unpacker #(.LANES(LANES)) u_unpack (
    .clk  (clk),
    .rst_n(rst_n),
    .cap  (rx_cap),
    .rx_in(eng_rx),
    .slot (rx_slot),
    .dout (rd_data)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    wr_left_d = wr_left_q;
    rd_left_d = rd_left_q;
    nw_d      = nw_q;
    nr_d      = nr_q;
    idx_d     = idx_q;
    tmo_d     = tmo_q;
    err_d     = err_q;
    tx_clr    = 1'b0;
    tx_push   = 1'b0;
    rx_cap    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          wr_left_d = wr_count;
          rd_left_d = rd_count;
          err_d     = 1'b0;
          state_d   = ST_PLAN;
        end
      end
      ST_PLAN: begin
        if (plan_work) begin
          nw_d      = plan_nw;
          nr_d      = plan_nr;
          wr_left_d = wr_left_q - CNT_W'(plan_nw);
          rd_left_d = rd_left_q - CNT_W'(plan_nr);
          idx_d     = '0;
          tx_clr    = 1'b1;
          state_d   = (plan_nw != '0) ? ST_FILL : ST_KICK;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (wr_valid) begin
          tx_push = 1'b1;
          idx_d   = idx_q + LANE_W'(1);
          if (idx_q == nw_q - LANE_W'(1)) begin
            state_d = ST_KICK;
          end
        end
      end
      ST_KICK: begin
        tmo_d   = '0;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (eng_done) begin
          rx_cap  = 1'b1;
          idx_d   = '0;
          state_d = (nr_q != '0) ? ST_DRAIN : ST_PLAN;
        end else if (tmo_q == TMO_W'(TMO_CYCLES - 1)) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tmo_d = tmo_q + TMO_W'(1);
        end
      end
      ST_DRAIN: begin
        if (rd_ready) begin
          idx_d = idx_q + LANE_W'(1);
          if (idx_q == nr_q - LANE_W'(1)) begin
            state_d = ST_PLAN;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    cs_n_d = (state_d == ST_IDLE);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_left_q <= '0;
      rd_left_q <= '0;
      nw_q      <= '0;
      nr_q      <= '0;
      idx_q     <= '0;
      tmo_q     <= '0;
      err_q     <= 1'b0;
      cs_n_q    <= 1'b1;
    end else begin
      state_q   <= state_d;
      wr_left_q <= wr_left_d;
      rd_left_q <= rd_left_d;
      nw_q      <= nw_d;
      nr_q      <= nr_d;
      idx_q     <= idx_d;
      tmo_q     <= tmo_d;
      err_q     <= err_d;
      cs_n_q    <= cs_n_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign error     = err_q;
  assign cs_n      = cs_n_q;
  assign wr_ready  = (state_q == ST_FILL);
  assign rd_valid  = (state_q == ST_DRAIN);
  assign eng_start = (state_q == ST_KICK);
  assign eng_bits  = BITS_W'(tot) * BITS_W'(8);

endmodule

// File: rtl/spi_chunk_seq_chk.sv
module spi_chunk_seq_chk #(
  parameter int LANES      = 4,
  parameter int TMO_CYCLES = 1000,
  parameter int BITS_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              error,
  input logic              cs_n,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_data,
  input logic              eng_start,
  input logic [BITS_W-1:0] eng_bits,
  input logic              eng_done
);

  // completion window tracker
  logic        pend_q;
  logic [31:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= '0;
    end else if (eng_start) begin
      pend_q <= 1'b1;
      wait_q <= '0;
    end else if (!busy || eng_done) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      wait_q <= wait_q + 32'd1;
    end
  end

  assert_bits_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_bits[2:0] == 3'd0) && (eng_bits != '0) &&
                  (32'(eng_bits) <= 32'(LANES * 8)));

  assert_cs_at_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !cs_n);

  assert_cs_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_wr_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && !cs_n));

  assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (wait_q <= 32'(TMO_CYCLES)));

  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (cs_n && !busy));

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !error);

endmodule

bind spi_chunk_seq spi_chunk_seq_chk #(
  .LANES     (LANES),
  .TMO_CYCLES(TMO_CYCLES),
  .BITS_W    (BITS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .error    (error),
  .cs_n     (cs_n),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .eng_start(eng_start),
  .eng_bits (eng_bits),
  .eng_done (eng_done)
);

// File: tb/sim_spi_chunk_seq.sv
module sim_spi_chunk_seq;

  localparam int CNT_W = 8;
  localparam int LANES = 4;
  localparam int TMO   = 20;
  localparam int WW    = LANES * 8;
  localparam int BW    = $clog2(WW + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             start;
  logic [CNT_W-1:0] wr_count, rd_count;
  logic             busy, error, cs_n;
  logic             wr_valid, wr_ready;
  logic [7:0]       wr_data;
  logic             rd_valid, rd_ready;
  logic [7:0]       rd_data;
  logic             eng_start;
  logic [BW-1:0]    eng_bits;
  logic [WW-1:0]    eng_tx;
  logic             eng_done;
  logic [WW-1:0]    eng_rx;

  spi_chunk_seq #(.CNT_W(CNT_W), .LANES(LANES), .TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_count(wr_count),
    .rd_count(rd_count), .busy(busy), .error(error), .cs_n(cs_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_start(eng_start), .eng_bits(eng_bits), .eng_tx(eng_tx),
    .eng_done(eng_done), .eng_rx(eng_rx)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit finished = 0;

  // bench-side environment controls (driven by main only)
  int  txn;
  int  cur_n;
  bit  mute;
  bit  en_io;
  bit  clr_logs;

  // logs (driven by the environment block only)
  int          wr_sent, rd_got, rounds, eng_cd;
  bit          wr_hs, rd_hs;
  logic [7:0]  rd_s;
  logic [7:0]  rd_log [16];
  logic [WW-1:0] tx_log [8];
  int          bits_log [8];
  logic        cs_log [8];

  function automatic logic [7:0] wr_byte(int t, int k);
    return 8'(t * 7 + k * 13 + 1);
  endfunction

  function automatic logic [WW-1:0] rx_of(int t, int r);
    return 32'h5A3C_9600 ^ {8'(t), 8'(r), 8'(t) ^ 8'hFF, 8'(r + 17)};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // environment: stream producer, consumer and shift-engine model
  always @(negedge clk) begin
    if (clr_logs) begin
      wr_sent = 0; rd_got = 0; rounds = 0; eng_cd = 0;
      wr_hs = 0; rd_hs = 0; eng_done = 0;
    end else begin
      if (wr_hs) wr_sent++;
      if (rd_hs) begin
        if (rd_got < 16) rd_log[rd_got] = rd_s;
        rd_got++;
      end
      eng_done = 1'b0;
      if (eng_cd > 0) begin
        eng_cd--;
        if (eng_cd == 0) begin
          eng_done = 1'b1;
          eng_rx   = rx_of(txn, rounds - 1);
        end
      end
      if (eng_start) begin
        if (rounds < 8) begin
          tx_log[rounds]   = eng_tx;
          bits_log[rounds] = int'(eng_bits);
          cs_log[rounds]   = cs_n;
        end
        rounds++;
        eng_cd = mute ? 0 : 3;
      end
    end
    wr_valid = en_io && (wr_sent < cur_n) && (cyc % 4 != 2);
    wr_data  = wr_byte(txn, wr_sent);
    rd_ready = en_io && (cyc % 3 != 1);
    #1;
    wr_hs = wr_valid && wr_ready;
    rd_hs = rd_valid && rd_ready;
    rd_s  = rd_data;
  end

  // run one exchange; returns cycles spent busy
  task automatic run_txn(int n, int m, output int spent, output bit hung);
    @(negedge clk); #2;
    clr_logs = 1;
    @(negedge clk); #2;
    clr_logs = 0;
    cur_n = n;
    wr_count = CNT_W'(n);
    rd_count = CNT_W'(m);
    start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
    check(busy && !cs_n, "R8", "busy/cs after start", {busy, cs_n}, 2'b10);
    check(!error, "R10", "error cleared by start", error, 0);
    spent = 1;
    hung = 0;
    while (busy) begin
      @(negedge clk); #3;
      spent++;
      if (spent > 3000) begin
        hung = 1;
        break;
      end
    end
    check(!hung, "R7", "exchange ended", hung, 0);
  endtask

  task automatic verify_txn(int n, int m);
    int wl = n, rl = m, r = 0, wk = 0, rk = 0;
    while (1) begin
      int nw, nr, tot;
      logic [WW-1:0] etx;
      nw = (wl < LANES) ? wl : LANES;
      nr = (rl < LANES - nw) ? rl : LANES - nw;
      tot = nw + nr;
      if (tot == 0) break;
      etx = '0;
      for (int i = 0; i < nw; i++) etx |= WW'(wr_byte(txn, wk + i)) << ((tot - 1 - i) * 8);
      if (r < rounds && r < 8) begin
        check(tx_log[r] == etx, "R4", $sformatf("tx word n=%0d m=%0d r=%0d", n, m, r), tx_log[r], etx);
        check(bits_log[r] == tot * 8, "R3", $sformatf("bits n=%0d m=%0d r=%0d", n, m, r), bits_log[r], tot * 8);
        check(cs_log[r] == 1'b0, "R7", "cs low at burst", cs_log[r], 0);
      end
      for (int i = 0; i < nr; i++) begin
        logic [7:0] e;
        e = 8'(rx_of(txn, r) >> ((nr - 1 - i) * 8));
        if (rk < 16 && rk < rd_got)
          check(rd_log[rk] == e, "R5", $sformatf("rd byte n=%0d m=%0d k=%0d", n, m, rk), rd_log[rk], e);
        rk++;
      end
      wk += nw; wl -= nw; rl -= nr; r++;
    end
    check(rounds == r, "R2", $sformatf("round count n=%0d m=%0d", n, m), rounds, r);
    check(wr_sent == n, "R6", "send bytes taken", wr_sent, n);
    check(rd_got == m, "R6", "receive bytes given", rd_got, m);
    check(cs_n && !busy && !error, "R7", "released at end", {cs_n, busy, error}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int spent;
    bit hung;
    rst_n = 0; start = 0; wr_count = '0; rd_count = '0;
    txn = 0; cur_n = 0; mute = 0; en_io = 1; clr_logs = 1;
    eng_rx = '0;
    repeat (3) @(negedge clk);
    #2;
    check(cs_n && !busy && !error && !wr_ready && !rd_valid && !eng_start,
          "R1", "outputs in reset", {cs_n, busy, error, wr_ready, rd_valid, eng_start}, 6'b100000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #2;
    check(cs_n && !busy && !error && !wr_ready && !rd_valid && !eng_start,
          "R1", "outputs after reset", {cs_n, busy, error, wr_ready, rd_valid, eng_start}, 6'b100000);

    // full sweep of send/receive counts (R2 R3 R4 R5 R6 R7 R11)
    for (int n = 0; n < 10; n++) begin
      for (int m = 0; m < 10; m++) begin
        txn = n * 10 + m + 1;
        run_txn(n, m, spent, hung);
        verify_txn(n, m);
      end
    end

    // silent engine: abort on timeout (R9)
    mute = 1;
    txn = 200;
    run_txn(2, 1, spent, hung);
    check(error == 1'b1, "R9", "error after timeout", error, 1);
    check(cs_n && !busy, "R9", "released after timeout", {cs_n, busy}, 2'b10);
    check(rd_got == 0, "R9", "no receive byte on abort", rd_got, 0);
    check(rounds == 1, "R9", "single burst before abort", rounds, 1);
    check(spent >= TMO, "R9", "waited the timeout", spent, TMO);
    repeat (5) @(negedge clk);
    #2;
    check(error == 1'b1, "R10", "error held while idle", error, 1);

    // recovery: next start clears the flag (R10)
    mute = 0;
    txn = 201;
    run_txn(3, 3, spent, hung);
    verify_txn(3, 3);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule